// File: doc/BRIEF.md
# Dock Predicate and Flag Unit

This block holds the three programmer-visible condition flags of a dock (A, B and the control flag C) and decides, for each instruction presented to it, whether that instruction executes or is ignored. The decision comes from a 3-bit predicate code carried in the top bits of the instruction. The code is tested against the flags and against a loop-counter-zero indication that the block receives from outside.

When an executing instruction is the flag-update form of the set instruction, the block computes new A and B values. Each one is an OR over a 6-bit selection of the old flags and their complements. When an executing instruction is a move, the block reloads C. Depending on the dock type and the instruction's data-capture bit, C takes either the incoming packet's signal bit or a control bit supplied by the ship. The execute decision is combinational from the presented word. Flag changes become visible one clock after an instruction is presented with its valid strobe high.

Top module: `dock_pred_flags`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears flag_a, flag_b and flag_c to 0.
- R2: When instr_valid is high and instr[21:19] is not 111, exec_ok follows the predicate code in instr[24:22]: 000 needs Z=0 and A=0; 001 needs Z=0 and A=1; 010 needs Z=0 and B=0; 011 needs Z=0 and B=1; 101 needs Z=1; 110 needs Z=0; 111 always passes.
- R3: Predicate code 100 never executes, whatever the flags and Z are, unless R4 applies.
- R4: An instruction whose instr[21:19] is 111 (loop marker) always gives exec_ok high when valid, whatever its predicate bits hold.
- R5: With instr_valid low, exec_ok is low and no flag changes at the next edge.
- R6: An executing flag-update instruction (instr[21:19]=101 and instr[18:15]=0001) loads A from the mask in instr[11:6] and B from the mask in instr[5:0]. Both masks are taken over the old flags, with mask bit 5 = A, bit 4 = not A, bit 3 = B, bit 2 = not B, bit 1 = C and bit 0 = not C. C is left unchanged.
- R7: A mask with no bit set loads 0 into its flag.
- R8: An executing move (instr[21]=0) at an input dock (dock_is_out=0) loads C from pkt_signal and leaves A and B unchanged.
- R9: An executing move at an output dock (dock_is_out=1) loads C from ship_ctl when instr[16] is 1, and from pkt_signal when instr[16] is 0.
- R10: An instruction whose predicate fails changes no flag.
- R11: Executing instructions of any other kind change no flag. This covers shift (100), abort (110), loop markers (111) and set instructions whose instr[18:15] is not 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 25 | Instruction word |
| instr_valid | input | 1 | Instruction word is present this cycle |
| lc_zero | input | 1 | Loop counter is zero (Z) |
| dock_is_out | input | 1 | 1 for an output dock, 0 for an input dock |
| pkt_signal | input | 1 | Signal bit of the incoming packet |
| ship_ctl | input | 1 | Control bit offered by the ship |
| exec_ok | output | 1 | Presented instruction executes (1) or is ignored (0) |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_c | output | 1 | Control flag C |

## Verification
The assertions assume that instr, lc_zero, pkt_signal and ship_ctl are stable around each rising edge and carry known values whenever instr_valid is high. They also assume that any instruction presented with instr_valid high is consumed in that single cycle. The stimulus meets these conditions by changing every input only on the falling clock edge and by driving fully defined words. It first sweeps all eight predicate codes across every A, B and Z combination, after setting the flags through flag-update words. It then issues random words whose opcode field is weighted toward moves and flag updates, with random masks, dock type and side bits.

// File: rtl/dock_flag_pkg.sv
// Package: shared instruction field positions and opcode classes for the
// dock predicate/flag unit. Assumes a 25-bit instruction word.
package dock_flag_pkg;

    localparam int OP_HI      = 21;
    localparam int OP_LO      = 19;
    localparam int DEST_HI    = 18;
    localparam int DEST_LO    = 15;
    localparam int CAPTURE_BIT = 16;

    localparam logic [2:0] OP_SET    = 3'b101;
    localparam logic [2:0] OP_MARKER = 3'b111;
    localparam logic [3:0] DEST_FLAGS = 4'b0001;

    typedef enum logic [1:0] {
        CLS_MOVE    = 2'd0,
        CLS_FLAGSET = 2'd1,
        CLS_MARKER  = 2'd2,
        CLS_OTHER   = 2'd3
    } instr_class_e;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } flags_t;

    // Sorts an instruction into the class that matters to the flag unit.
    function automatic instr_class_e classify(input logic [2:0] op,
                                              input logic [3:0] dest);
        if (!op[2])
            return CLS_MOVE;
        else if (op == OP_MARKER)
            return CLS_MARKER;
        else if (op == OP_SET && dest == DEST_FLAGS)
            return CLS_FLAGSET;
        else
            return CLS_OTHER;
    endfunction

endpackage

// File: rtl/pred_eval.sv
// Module: pred_eval
// Evaluates a predicate code against flags A, B and the loop-zero input.
// Assumes the caller has already decided whether the word carries a
// predicate; 'bypass' forces a pass for words without one.
module pred_eval #(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code,
    input  logic              bypass,
    input  logic              flag_a,
    input  logic              flag_b,
    input  logic              zero,
    output logic              pass
);
    localparam int NUM_CODES = 1 << CODE_W;

    logic [NUM_CODES-1:0] table_hit;

    // Builds the per-code outcome vector from the current conditions.
    always_comb begin
        table_hit = '0;
        table_hit[0] = !zero && !flag_a;
        table_hit[1] = !zero &&  flag_a;
        table_hit[2] = !zero && !flag_b;
        table_hit[3] = !zero &&  flag_b;
        table_hit[4] = 1'b0;             // reserved code: never executes
        table_hit[5] =  zero;
        table_hit[6] = !zero;
        table_hit[7] = 1'b1;
    end

    // Selects the outcome for the presented code, or passes unconditionally.
    always_comb begin
        pass = bypass || table_hit[code];
    end
endmodule

// File: rtl/flag_mask_update.sv
// Module: flag_mask_update
// Computes new values for NUM_FLAGS flags, each an OR over a MASK_W-bit
// selection of old flag terms. The mask for flag 0 sits in the most
// significant slice. Assumes the term vector is ordered to match the mask.
module flag_mask_update #(
    parameter int MASK_W    = 6,
    parameter int NUM_FLAGS = 2
) (
    input  logic [NUM_FLAGS*MASK_W-1:0] masks,
    input  logic [MASK_W-1:0]           terms,
    output logic [NUM_FLAGS-1:0]        new_vals
);
    localparam int TOTAL_W = NUM_FLAGS * MASK_W;

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        localparam int TOP = TOTAL_W - 1 - k * MASK_W;
        logic [MASK_W-1:0] sel;
        // Picks this flag's mask slice and reduces the selected terms.
        always_comb begin
            sel = masks[TOP -: MASK_W];
            new_vals[k] = |(sel & terms);
        end
    end
endmodule

// File: rtl/ctl_flag_select.sv
// Module: ctl_flag_select
// Chooses the next control-flag value for an executing move.
// Assumes dock type is static while instructions flow.
module ctl_flag_select (
    input  logic is_output_dock,
    input  logic capture_bit,
    input  logic pkt_signal,
    input  logic ship_ctl,
    output logic c_next
);
    // Output docks with capture take the ship's bit; all else the packet's.
    always_comb begin
        c_next = (is_output_dock && capture_bit) ? ship_ctl : pkt_signal;
    end
endmodule

// File: rtl/dock_pred_flags.sv
// Module: dock_pred_flags
// Keeps dock flags A, B, C; gives an execute decision for each presented
// instruction and applies flag updates for executing flag-set and move words.
// Assumes each valid word is consumed in the cycle it is presented.
module dock_pred_flags
    import dock_flag_pkg::*;
#(
    parameter int INSTR_W = 25,
    parameter int CODE_W  = 3,
    parameter int MASK_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               instr_valid,
    input  logic               lc_zero,
    input  logic               dock_is_out,
    input  logic               pkt_signal,
    input  logic               ship_ctl,
    output logic               exec_ok,
    output logic               flag_a,
    output logic               flag_b,
    output logic               flag_c
);
    localparam int NUM_MASKED = 2;
    localparam int CODE_LO    = INSTR_W - CODE_W;
    localparam int MASKS_W    = NUM_MASKED * MASK_W;

    flags_t            flags_q;
    instr_class_e      cls;
    logic              pred_pass;
    logic [MASK_W-1:0] terms;
    logic [NUM_MASKED-1:0] ab_next;
    logic              c_next;
    logic              unused_bits;

    assign unused_bits = ^instr[DEST_LO-1:MASKS_W];

    // Classifies the presented word.
    always_comb begin
        cls = classify(instr[OP_HI:OP_LO], instr[DEST_HI:DEST_LO]);
    end

    pred_eval #(.CODE_W(CODE_W)) u_pred (
        .code   (instr[INSTR_W-1:CODE_LO]),
        .bypass (cls == CLS_MARKER),
        .flag_a (flags_q.a),
        .flag_b (flags_q.b),
        .zero   (lc_zero),
        .pass   (pred_pass)
    );

    // Forms the old-flag term vector in mask bit order.
    always_comb begin
        terms = {flags_q.a, !flags_q.a, flags_q.b, !flags_q.b,
                 flags_q.c, !flags_q.c};
    end

    flag_mask_update #(.MASK_W(MASK_W), .NUM_FLAGS(NUM_MASKED)) u_mask (
        .masks    (instr[MASKS_W-1:0]),
        .terms    (terms),
        .new_vals (ab_next)
    );

    ctl_flag_select u_csel (
        .is_output_dock (dock_is_out),
        .capture_bit    (instr[CAPTURE_BIT]),
        .pkt_signal     (pkt_signal),
        .ship_ctl       (ship_ctl),
        .c_next         (c_next)
    );

    // Gates the decision with the valid strobe.
    always_comb begin
        exec_ok = instr_valid && pred_pass;
    end

    // Holds the flags; applies the update chosen by the executing word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (exec_ok) begin
            if (cls == CLS_FLAGSET) begin
                flags_q.a <= ab_next[0];
                flags_q.b <= ab_next[1];
            end else if (cls == CLS_MOVE) begin
                flags_q.c <= c_next;
            end
        end
    end

    assign flag_a = flags_q.a;
    assign flag_b = flags_q.b;
    assign flag_c = flags_q.c;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!flag_a && !flag_b && !flag_c));

    // R3
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[INSTR_W-1:CODE_LO] == 3'b100 &&
         instr[OP_HI:OP_LO] != OP_MARKER) |-> !exec_ok);

    // R4
    marker_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[OP_HI:OP_LO] == OP_MARKER) |-> exec_ok);

    // R5
    idle_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !exec_ok);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(flag_a) && $stable(flag_b) && $stable(flag_c)));

    // R10
    ignored_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !exec_ok) |=>
        ($stable(flag_a) && $stable(flag_b) && $stable(flag_c)));

    // R8
    input_dock_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ok && !instr[OP_HI] && !dock_is_out) |=>
        (flag_c == $past(pkt_signal)));

    // R6
    flagset_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ok && instr[OP_HI:OP_LO] == OP_SET &&
         instr[DEST_HI:DEST_LO] == DEST_FLAGS) |=> $stable(flag_c));
endmodule

// File: tb/dock_pred_flags_test.sv
module dock_pred_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [24:0] instr = '0;
    logic        instr_valid = 1'b0;
    logic        lc_zero = 1'b0;
    logic        dock_is_out = 1'b0;
    logic        pkt_signal = 1'b0;
    logic        ship_ctl = 1'b0;
    logic        exec_ok, flag_a, flag_b, flag_c;

    int checks = 0;
    int fails  = 0;
    logic ma = 1'b0, mb = 1'b0, mc = 1'b0;

    always #4 clk = ~clk;

    dock_pred_flags uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid),
        .lc_zero(lc_zero), .dock_is_out(dock_is_out), .pkt_signal(pkt_signal),
        .ship_ctl(ship_ctl), .exec_ok(exec_ok), .flag_a(flag_a),
        .flag_b(flag_b), .flag_c(flag_c)
    );

    function automatic logic exp_exec(logic [24:0] i, logic v, logic a,
                                      logic b, logic z);
        if (!v) return 1'b0;
        if (i[21:19] == 3'b111) return 1'b1;
        case (i[24:22])
            3'b000: return !z && !a;
            3'b001: return !z && a;
            3'b010: return !z && !b;
            3'b011: return !z && b;
            3'b101: return z;
            3'b110: return !z;
            3'b111: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string exec_tag(logic [24:0] i, logic v);
        if (!v) return "R5";
        if (i[21:19] == 3'b111) return "R4";
        if (i[24:22] == 3'b100) return "R3";
        return "R2";
    endfunction

    function automatic logic [2:0] exp_flags(logic [24:0] i, logic ex, logic a,
                                             logic b, logic c, logic out,
                                             logic sig, logic ship);
        logic [5:0] t;
        t = {a, !a, b, !b, c, !c};
        if (!ex) return {a, b, c};
        if (i[21:19] == 3'b101 && i[18:15] == 4'b0001)
            return {|(i[11:6] & t), |(i[5:0] & t), c};
        if (!i[21])
            return {a, b, (out && i[16]) ? ship : sig};
        return {a, b, c};
    endfunction

    function automatic string flag_tag(logic [24:0] i, logic v, logic ex,
                                       logic out);
        if (!v) return "R5";
        if (!ex) return "R10";
        if (i[21:19] == 3'b101 && i[18:15] == 4'b0001)
            return (i[11:6] == 6'd0 || i[5:0] == 6'd0) ? "R7" : "R6";
        if (!i[21]) return out ? "R9" : "R8";
        return "R11";
    endfunction

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Presents one word for one cycle, checks decision and resulting flags.
    task automatic step(logic [24:0] i, logic v, logic z, logic out,
                        logic sig, logic ship);
        logic e;
        logic [2:0] nf;
        @(negedge clk);
        instr = i; instr_valid = v; lc_zero = z;
        dock_is_out = out; pkt_signal = sig; ship_ctl = ship;
        #1;
        e = exp_exec(i, v, ma, mb, z);
        check(exec_tag(i, v), {2'b00, exec_ok}, {2'b00, e});
        nf = exp_flags(i, e, ma, mb, mc, out, sig, ship);
        @(posedge clk);
        #1;
        check(flag_tag(i, v, e, out), {flag_a, flag_b, flag_c}, nf);
        {ma, mb, mc} = nf;
    endtask

    function automatic logic [24:0] flagset(logic [5:0] am, logic [5:0] bm);
        return {3'b111, 3'b101, 4'b0001, 3'b000, am, bm};
    endfunction

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {flag_a, flag_b, flag_c}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset after flags were set
        step(flagset(6'b110000, 6'b110000), 1, 0, 0, 0, 0);
        step(25'h0, 1, 0, 0, 1, 0);
        @(negedge clk); rst_n = 1'b0; instr_valid = 1'b0;
        @(posedge clk); #1;
        check("R1", {flag_a, flag_b, flag_c}, 3'b000);
        {ma, mb, mc} = 3'b000;
        @(negedge clk); rst_n = 1'b1;

        // R2/R3/R11: every predicate code over every A, B, Z
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                step(flagset(a[0] ? 6'b110000 : 6'b000000,
                             b[0] ? 6'b001100 : 6'b000000), 1, 0, 0, 0, 0);
                for (int z = 0; z < 2; z++) begin
                    for (int p = 0; p < 8; p++) begin
                        step({p[2:0], 3'b100, 19'h1abc5}, 1, z[0], 0, 0, 0);
                    end
                end
            end
        end

        // R4: loop markers with reserved predicate and with Z set
        step({3'b100, 3'b111, 1'b0, 18'h0}, 1, 1, 0, 0, 0);
        step({3'b000, 3'b111, 1'b1, 18'h0}, 1, 1, 0, 1, 1);
        // R7: empty masks clear both flags
        step(flagset(6'b110000, 6'b001100), 1, 0, 0, 0, 0);
        step(flagset(6'b000000, 6'b000000), 1, 0, 0, 0, 0);
        // R6: swap-like simultaneous update (A<=B, B<=A)
        step(flagset(6'b110000, 6'b000000), 1, 0, 0, 0, 0);
        step(flagset(6'b001000, 6'b100000), 1, 0, 0, 0, 0);
        // R9: output dock with and without capture bit
        step({3'b111, 5'b00000, 1'b1, 16'h0}, 1, 0, 1, 0, 1);
        step({3'b111, 5'b00000, 1'b0, 16'h0}, 1, 0, 1, 0, 1);
        // R8: input dock ignores ship bit even with capture bit
        step({3'b111, 5'b00000, 1'b1, 16'h0}, 1, 0, 0, 1, 0);
        // R5: idle cycle with a move word present
        step({3'b111, 22'h0}, 0, 0, 0, 0, 1);
        // R11: set with another destination, abort
        step({3'b111, 3'b101, 4'b1000, 15'h7fff}, 1, 0, 0, 0, 0);
        step({3'b111, 3'b110, 19'h7ffff}, 1, 0, 0, 0, 0);

        // Random mix weighted toward moves and flag updates
        for (int n = 0; n < 3000; n++) begin
            logic [24:0] w;
            logic [3:0] pick;
            w = 25'($urandom);
            pick = 4'($urandom);
            if (pick < 6) w[21] = 1'b0;
            else if (pick < 11) begin w[21:19] = 3'b101; w[18:15] = 4'b0001; end
            step(w, ($urandom % 8) != 0, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end
endmodule